// File: doc/BRIEF.md
# SPI Target Supply Supervisor

This block watches a stream of digitized readings of the supply rail that feeds an external SPI flash target and decides what happens to that rail and to the SPI traffic running over it. Each reading is in millivolts and comes with a one-cycle valid strobe. A reading under 2700 mV lights a warning LED. The LED goes dark again only after a programmable run of consecutive healthy readings.

While the warning is lit and recovery is enabled, the block interrupts the SPI job periodically. It asks the SPI engine to pause, waiting for a gap between bytes to do so. It then switches the rail off for a bounded suspend time, powers it back up, and waits for the power-good signal. A configuration input turns this recovery off, so that SPI work runs on with only the LED lit.

A reading under a programmable critical level works differently. The block removes target power at once, stops the SPI engine with an abort flag, and holds that state until software pulses a clear. A rail that fails to report power-good in time after power is restored also leads to the abort state, and this case additionally sets a timeout flag. Either way the host system keeps running instead of browning out.

Top module: `vspi_supervisor`

## Requirements
- R1: On a valid reading strictly below 2700 mV the warning LED is lit from the next clock edge; a reading of exactly 2700 mV does not light it.
- R2: The lit LED clears on the N-th consecutive valid reading at or above 2700 mV, where N is `hyst_cnt_i` (0 acts as 1). A low reading restarts the run. Cycles without a valid strobe change nothing.
- R3: With `recover_dis_i` low and the LED lit, the rail stays on for RUN_CYC cycles. Then `pwr_en_o` drops for exactly SUSP_CYC cycles with `pause_req_o` high, then a power-up wait follows, and the cycle repeats while the LED stays lit.
- R4: With `recover_dis_i` high, a lit LED never removes power or requests a pause.
- R5: `pause_req_o` rises only on an edge at which `spi_busy_i` was low; a due suspend is postponed while the engine is mid-byte.
- R6: A valid reading strictly below the effective critical level sets `abort_o` at the next edge from any state. While aborted, `pwr_en_o` and `pause_req_o` are low.
- R7: The effective critical level is the lesser of `crit_mv_i` and 2699 mV, so it always lies under the warning threshold.
- R8: `abort_o` stays set until a cycle with `abort_clr_i` high and no critical reading. The next state is then the power-up wait, with power on and pause requested.
- R9: In the power-up wait, `pgood_i` high returns to normal running at the next edge. If `pgood_i` stays low for PG_CYC cycles, the block aborts and sets `pg_tout_o`, which a clear resets.
- R10: A single suspend never lasts SUSP_MAX_CYC cycles (5 s at the default clock) or more.
- R11: After reset the LED, pause, abort and timeout outputs are low and `pwr_en_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| adc_mv_i | input | MV_W | Supply reading in millivolts |
| adc_valid_i | input | 1 | Reading valid strobe |
| crit_mv_i | input | MV_W | Programmed critical level in millivolts |
| hyst_cnt_i | input | HYST_W | Healthy readings needed to clear the LED |
| recover_dis_i | input | 1 | 1 disables the periodic suspend cycle |
| spi_busy_i | input | 1 | SPI engine is inside a byte |
| pgood_i | input | 1 | Power-good from the rail switch |
| abort_clr_i | input | 1 | Pulse to leave the abort state |
| warn_led_o | output | 1 | Low-supply warning LED |
| pwr_en_o | output | 1 | Target supply enable |
| pause_req_o | output | 1 | Pause request to the SPI engine |
| abort_o | output | 1 | Abort flag to the SPI engine |
| pg_tout_o | output | 1 | Power-good timeout flag |

## Verification
The LED filter gets readings scattered on both sides of 2700 mV, with random gaps in the strobe and random hysteresis counts. These are compared against a bench model, which separates an off-by-one in the threshold or in the run count from a strobe that leaks through. Directed sequences measure the exact run and suspend lengths of the recovery cycle. They also hold the engine busy across a due suspend, which shows whether the pause waits for a byte gap. Readings placed exactly on and one below the critical level, with the programmed level set above and below the warning level, show the strict comparison and the clamp. Entering an abort from the suspend state, letting power-good fail and recover, and clearing an abort show the latch and the power-good timeout.

// File: rtl/vspi_sup_pkg.sv
package vspi_sup_pkg;
  typedef enum logic [1:0] {
    ST_RUN   = 2'd0,
    ST_SUSP  = 2'd1,
    ST_PWRUP = 2'd2,
    ST_ABORT = 2'd3
  } sup_st_e;
endpackage

// File: rtl/vspi_warn_filt.sv
module vspi_warn_filt #(
  parameter int MV_W    = 12,
  parameter int WARN_MV = 2700,
  parameter int HYST_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [MV_W-1:0]   sample_i,
  input  logic              valid_i,
  input  logic [HYST_W-1:0] hyst_i,
  output logic              warn_o
);
  logic [HYST_W-1:0] ok_cnt;
  logic [HYST_W:0]   need;
  logic              below;

  assign below = sample_i < MV_W'(WARN_MV);
  assign need  = (hyst_i == '0) ? (HYST_W+1)'(1) : {1'b0, hyst_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      warn_o <= 1'b0;
      ok_cnt <= '0;
    end else if (valid_i) begin
      if (below) begin
        warn_o <= 1'b1;
        ok_cnt <= '0;
      end else if (warn_o) begin
        if (({1'b0, ok_cnt} + (HYST_W+1)'(1)) >= need) begin
          warn_o <= 1'b0;
          ok_cnt <= '0;
        end else begin
          ok_cnt <= ok_cnt + 1'b1;
        end
      end
    end
  end

  AST_LED_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && below |=> warn_o); // R1
  AST_LED_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(warn_o)); // R2
endmodule

// File: rtl/vspi_crit_det.sv
module vspi_crit_det #(
  parameter int MV_W    = 12,
  parameter int WARN_MV = 2700
) (
  input  logic [MV_W-1:0] sample_i,
  input  logic            valid_i,
  input  logic [MV_W-1:0] crit_mv_i,
  output logic            crit_hit_o
);
  localparam logic [MV_W-1:0] CapMv = MV_W'(WARN_MV - 1);

  logic [MV_W-1:0] eff_mv;

  // critical level is forced under the warning level
  assign eff_mv     = (crit_mv_i > CapMv) ? CapMv : crit_mv_i;
  assign crit_hit_o = valid_i && (sample_i < eff_mv);

  always_comb begin
    if (crit_hit_o) begin
      AST_CRIT_UNDER_WARN: assert (sample_i < MV_W'(WARN_MV - 1)); // R7
    end
  end
endmodule

// File: rtl/vspi_pwr_seq.sv
module vspi_pwr_seq
  import vspi_sup_pkg::*;
#(
  parameter int RUN_CYC      = 50_000_000,
  parameter int SUSP_CYC     = 10_000_000,
  parameter int PG_CYC       = 1_250_000,
  parameter int SUSP_MAX_CYC = 250_000_000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic warn_i,
  input  logic recover_dis_i,
  input  logic crit_hit_i,
  input  logic spi_busy_i,
  input  logic pgood_i,
  input  logic abort_clr_i,
  output logic pwr_en_o,
  output logic pause_req_o,
  output logic abort_o,
  output logic pg_tout_o
);
  localparam int TmrMax = (RUN_CYC > SUSP_CYC) ?
                          ((RUN_CYC > PG_CYC) ? RUN_CYC : PG_CYC) :
                          ((SUSP_CYC > PG_CYC) ? SUSP_CYC : PG_CYC);
  localparam int TmrW   = $clog2(TmrMax + 1);
  localparam int SlW    = $clog2(SUSP_MAX_CYC + 1);

  sup_st_e         st_q;
  logic [TmrW-1:0] tmr_q;
  logic            cycle_en;

  assign cycle_en = warn_i && !recover_dis_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_RUN;
      tmr_q     <= '0;
      pg_tout_o <= 1'b0;
    end else if (crit_hit_i && st_q != ST_ABORT) begin
      st_q  <= ST_ABORT;
      tmr_q <= '0;
    end else begin
      unique case (st_q)
        ST_RUN: begin
          if (!cycle_en) begin
            tmr_q <= '0;
          end else if (tmr_q == TmrW'(RUN_CYC - 1)) begin
            if (!spi_busy_i) begin  // suspend only in a byte gap
              st_q  <= ST_SUSP;
              tmr_q <= '0;
            end
          end else begin
            tmr_q <= tmr_q + 1'b1;
          end
        end
        ST_SUSP: begin
          if (tmr_q == TmrW'(SUSP_CYC - 1)) begin
            st_q  <= ST_PWRUP;
            tmr_q <= '0;
          end else begin
            tmr_q <= tmr_q + 1'b1;
          end
        end
        ST_PWRUP: begin
          if (pgood_i) begin
            st_q  <= ST_RUN;
            tmr_q <= '0;
          end else if (tmr_q == TmrW'(PG_CYC - 1)) begin
            st_q      <= ST_ABORT;
            tmr_q     <= '0;
            pg_tout_o <= 1'b1;
          end else begin
            tmr_q <= tmr_q + 1'b1;
          end
        end
        ST_ABORT: begin
          if (abort_clr_i && !crit_hit_i) begin
            st_q      <= ST_PWRUP;
            tmr_q     <= '0;
            pg_tout_o <= 1'b0;
          end
        end
        default: st_q <= ST_ABORT;
      endcase
    end
  end

  assign pwr_en_o    = (st_q == ST_RUN) || (st_q == ST_PWRUP);
  assign pause_req_o = (st_q == ST_SUSP) || (st_q == ST_PWRUP);
  assign abort_o     = (st_q == ST_ABORT);

  // checker: length of the current suspend
  logic [SlW-1:0] susp_len_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 susp_len_q <= '0;
    else if (st_q != ST_SUSP)    susp_len_q <= '0;
    else if (susp_len_q != '1)   susp_len_q <= susp_len_q + 1'b1;
  end

  AST_SUSP_MAX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_q == ST_SUSP |-> susp_len_q < SlW'(SUSP_MAX_CYC)); // R10
  AST_PAUSE_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pause_req_o) && !abort_o && !$past(abort_o) |-> !$past(spi_busy_i)); // R5
  AST_CRIT_ABORT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    crit_hit_i |=> abort_o && !pwr_en_o); // R6
  AST_ABORT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_o && !abort_clr_i |=> abort_o); // R8
  AST_NO_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_q == ST_RUN && recover_dis_i && !crit_hit_i |=> pwr_en_o && !pause_req_o); // R4
  AST_TOUT_ABORT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pg_tout_o) |-> abort_o && $past(st_q == ST_PWRUP)); // R9
endmodule

// File: rtl/vspi_supervisor.sv
module vspi_supervisor #(
  parameter int MV_W         = 12,
  parameter int WARN_MV      = 2700,
  parameter int HYST_W       = 4,
  parameter int RUN_CYC      = 50_000_000,
  parameter int SUSP_CYC     = 10_000_000,
  parameter int PG_CYC       = 1_250_000,
  parameter int SUSP_MAX_CYC = 250_000_000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [MV_W-1:0]   adc_mv_i,
  input  logic              adc_valid_i,
  input  logic [MV_W-1:0]   crit_mv_i,
  input  logic [HYST_W-1:0] hyst_cnt_i,
  input  logic              recover_dis_i,
  input  logic              spi_busy_i,
  input  logic              pgood_i,
  input  logic              abort_clr_i,
  output logic              warn_led_o,
  output logic              pwr_en_o,
  output logic              pause_req_o,
  output logic              abort_o,
  output logic              pg_tout_o
);
  logic crit_hit;

  vspi_warn_filt #(
    .MV_W(MV_W), .WARN_MV(WARN_MV), .HYST_W(HYST_W)
  ) u_warn (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .sample_i(adc_mv_i),
    .valid_i (adc_valid_i),
    .hyst_i  (hyst_cnt_i),
    .warn_o  (warn_led_o)
  );

  vspi_crit_det #(
    .MV_W(MV_W), .WARN_MV(WARN_MV)
  ) u_crit (
    .sample_i  (adc_mv_i),
    .valid_i   (adc_valid_i),
    .crit_mv_i (crit_mv_i),
    .crit_hit_o(crit_hit)
  );

  vspi_pwr_seq #(
    .RUN_CYC(RUN_CYC), .SUSP_CYC(SUSP_CYC),
    .PG_CYC(PG_CYC), .SUSP_MAX_CYC(SUSP_MAX_CYC)
  ) u_seq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .warn_i       (warn_led_o),
    .recover_dis_i(recover_dis_i),
    .crit_hit_i   (crit_hit),
    .spi_busy_i   (spi_busy_i),
    .pgood_i      (pgood_i),
    .abort_clr_i  (abort_clr_i),
    .pwr_en_o     (pwr_en_o),
    .pause_req_o  (pause_req_o),
    .abort_o      (abort_o),
    .pg_tout_o    (pg_tout_o)
  );

  AST_OFF_WHEN_ABORT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_o |-> !pwr_en_o && !pause_req_o); // R6
endmodule

// File: tb/vspi_supervisor_bench.sv
module vspi_supervisor_bench;
  localparam int MV_W = 12, HYST_W = 4;
  localparam int RUN_CYC = 20, SUSP_CYC = 10, PG_CYC = 8, SUSP_MAX_CYC = 12;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic [MV_W-1:0] adc_mv_i = '0, crit_mv_i = '0;
  logic adc_valid_i = 1'b0, recover_dis_i = 1'b1, spi_busy_i = 1'b0;
  logic pgood_i = 1'b1, abort_clr_i = 1'b0;
  logic [HYST_W-1:0] hyst_cnt_i = 4'd1;
  logic warn_led_o, pwr_en_o, pause_req_o, abort_o, pg_tout_o;

  int errors = 0, checks = 0;
  bit exp_led = 1'b0;
  int exp_cnt = 0;

  always #4 clk_i = ~clk_i;

  vspi_supervisor #(
    .MV_W(MV_W), .WARN_MV(2700), .HYST_W(HYST_W), .RUN_CYC(RUN_CYC),
    .SUSP_CYC(SUSP_CYC), .PG_CYC(PG_CYC), .SUSP_MAX_CYC(SUSP_MAX_CYC)
  ) u_vspi_supervisor (.*);

  task automatic tick();
    @(posedge clk_i);
    #2;
  endtask

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic send(int mv);
    adc_mv_i = MV_W'(mv);
    adc_valid_i = 1'b1;
    tick();
    adc_valid_i = 1'b0;
  endtask

  // next LED value from the R1/R2 rules
  function automatic void led_model(bit vld, int mv, int hyst);
    int need;
    need = (hyst == 0) ? 1 : hyst;
    if (!vld) return;
    if (mv < 2700) begin
      exp_led = 1'b1; exp_cnt = 0;
    end else if (exp_led) begin
      if (exp_cnt + 1 >= need) begin exp_led = 1'b0; exp_cnt = 0; end
      else exp_cnt++;
    end
  endfunction

  task automatic wait_for(string req, bit want_pwr, bit want_pause, bit use_pause);
    int n = 0;
    while (((use_pause ? pause_req_o : pwr_en_o) != (use_pause ? want_pause : want_pwr)) && n < 200) begin
      tick(); n++;
    end
    chk(req, n < 200, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog actual=expired expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int n;
    void'($urandom(32'd4711));
    repeat (3) tick();
    // R11 reset state
    chk("R11 led", warn_led_o, 0); chk("R11 pwr", pwr_en_o, 1);
    chk("R11 pause", pause_req_o, 0); chk("R11 abort", abort_o, 0);
    chk("R11 tout", pg_tout_o, 0);
    rst_ni = 1'b1;
    tick();

    // R1 threshold edge
    send(2700); chk("R1 at 2700", warn_led_o, 0);
    send(2699); chk("R1 at 2699", warn_led_o, 1);
    // R2 hysteresis run
    hyst_cnt_i = 4'd3;
    send(3000); send(3000); chk("R2 two ok", warn_led_o, 1);
    send(2000); send(3000); send(3000); chk("R2 restart", warn_led_o, 1);
    send(3000); chk("R2 third ok", warn_led_o, 0);

    // R1 R2 random against model
    exp_led = 1'b0; exp_cnt = 0;
    for (int i = 0; i < 400; i++) begin
      bit v = 1'($urandom_range(1, 0));
      int mv = int'($urandom_range(2800, 2600));
      if ((i % 37) == 0) hyst_cnt_i = HYST_W'($urandom_range(15, 0));
      adc_mv_i = MV_W'(mv);
      adc_valid_i = v;
      tick();
      adc_valid_i = 1'b0;
      led_model(v, mv, int'(hyst_cnt_i));
      chk("R2 random led", warn_led_o, int'(exp_led));
    end

    // R4 recovery disabled
    hyst_cnt_i = 4'd1;
    send(2000);
    n = 0;
    for (int i = 0; i < 60; i++) begin
      tick();
      if (!pwr_en_o || pause_req_o) n++;
    end
    chk("R4 no suspend", n, 0);
    chk("R4 led still lit", warn_led_o, 1);

    // R3 periodic cycle
    recover_dis_i = 1'b0;
    wait_for("R3 reach suspend", 1'b0, 1'b0, 1'b0);
    chk("R3 pause in suspend", pause_req_o, 1);
    n = 0;
    while (!pwr_en_o && n < 50) begin tick(); n++; end
    chk("R3 suspend length", n, SUSP_CYC);
    chk("R10 suspend under max", int'(n < SUSP_MAX_CYC), 1);
    chk("R3 powerup pause", pause_req_o, 1);
    tick();
    chk("R3 back to run", pause_req_o, 0);
    n = 0;
    while (pwr_en_o && n < 100) begin tick(); n++; end
    chk("R3 run length", n, RUN_CYC);

    // R5 suspend deferred while busy
    wait_for("R5 reach run", 1'b0, 1'b0, 1'b1);
    spi_busy_i = 1'b1;
    n = 0;
    for (int i = 0; i < 40; i++) begin
      tick();
      if (!pwr_en_o || pause_req_o) n++;
    end
    chk("R5 no pause mid byte", n, 0);
    spi_busy_i = 1'b0;
    tick();
    chk("R5 pause in gap", pause_req_o, 1);
    chk("R5 power off in gap", pwr_en_o, 0);

    // R9 power-good timeout
    pgood_i = 1'b0;
    wait_for("R9 reach powerup", 1'b1, 1'b0, 1'b0);
    n = 0;
    while (!abort_o && n < 50) begin tick(); n++; end
    chk("R9 timeout length", n, PG_CYC);
    chk("R9 tout flag", pg_tout_o, 1);
    chk("R6 power off in abort", pwr_en_o, 0);
    chk("R6 pause low in abort", pause_req_o, 0);

    // R8 latch
    recover_dis_i = 1'b1;
    n = 0;
    for (int i = 0; i < 20; i++) begin
      send(3000);
      if (!abort_o) n++;
    end
    chk("R8 abort held", n, 0);
    pgood_i = 1'b1;
    abort_clr_i = 1'b1; tick(); abort_clr_i = 1'b0;
    chk("R8 cleared", abort_o, 0); chk("R9 tout cleared", pg_tout_o, 0);
    chk("R8 powerup pwr", pwr_en_o, 1); chk("R8 powerup pause", pause_req_o, 1);
    tick();
    chk("R9 pgood to run", pause_req_o, 0);

    // R6 strict compare
    crit_mv_i = 12'd2500;
    send(2500); chk("R6 at level", abort_o, 0);
    send(2499); chk("R6 below level", abort_o, 1);
    chk("R6 pwr off", pwr_en_o, 0);

    // R7 clamp
    abort_clr_i = 1'b1; tick(); abort_clr_i = 1'b0; tick();
    crit_mv_i = 12'd3000;
    send(2800); chk("R7 above warn", abort_o, 0);
    send(2699); chk("R7 at clamp", abort_o, 0);
    chk("R7 led lit", warn_led_o, 1);
    send(2698); chk("R7 under clamp", abort_o, 1);

    // R9 late power-good
    pgood_i = 1'b0;
    abort_clr_i = 1'b1; tick(); abort_clr_i = 1'b0;
    repeat (3) tick();
    chk("R9 waiting pause", pause_req_o, 1);
    chk("R9 waiting pwr", pwr_en_o, 1);
    pgood_i = 1'b1; tick();
    chk("R9 late pgood run", pause_req_o, 0);
    chk("R9 no tout", pg_tout_o, 0);

    // R6 from suspend
    crit_mv_i = 12'd1000;
    send(2000);
    recover_dis_i = 1'b0;
    wait_for("R6 reach suspend", 1'b0, 1'b0, 1'b0);
    send(500);
    chk("R6 abort from suspend", abort_o, 1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule